// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Register Interface

This block is the slave end of an 8-bit bus on which address and data take turns on the same lines. It sits in front of a 128-byte store that holds registers and RAM. A bus cycle has two phases. In the first, the master pulses the address strobe, and the falling edge of that strobe captures the location. In the second, the master raises the data strobe. With the read/write-not line high, the block drives the stored byte back onto the shared lines. With that line low, the byte on the lines is stored when the data strobe falls. The shared lines are modelled as three signals: an input, an output and an output enable.

All bus pins are asynchronous to the block. They pass through synchronisers into the system clock domain, and edges are detected there. A strobe edge takes effect `SYNC_STAGES + 1` system clocks after it reaches the pin. The shared data lines pass through a delay line of the same depth, so that data and strobes stay aligned.

A power-valid input and an oscillator tick drive a lockout. While power is bad, and for `HOLDOFF_TICKS` oscillator ticks after it returns or after reset, the block ignores writes and never drives the lines. Chip select gates access in the same way.

Top module: `mbus_regif`

## Requirements
- R1: The falling edge of `as_i` captures the location on `ad_in`. That location then stays fixed until the next falling edge of `as_i`, so it covers the data phase that follows.
- R2: Only `ad_in[6:0]` of the captured byte selects one of the 128 locations. Bit 7 is ignored, so address `8'h83` reaches the same byte as `8'h03`.
- R3: In a data phase with `rd_wrn` = 0, the falling edge of `ds_i` writes the byte on `ad_in` to the captured location.
- R4: In a data phase with `rd_wrn` = 1 and `ds_i` = 1, `ad_oe` is 1 and `ad_out` carries the byte last written to the captured location.
- R5: `ad_oe` is 0 outside read data phases, including the whole of every write cycle. It returns to 0 within `SYNC_STAGES + 2` clocks after `ds_i` falls.
- R6: While `pwr_ok` = 0, writes have no effect on the stored bytes and `ad_oe` stays 0.
- R7: After `pwr_ok` returns to 1, and after reset, the block stays deselected until `HOLDOFF_TICKS` oscillator ticks have been counted. Writes and reads in that window behave as in R6. Once the window ends, access resumes.
- R8: While `cs_n` = 1, writes have no effect on the stored bytes and `ad_oe` stays 0.
- R9: While `rst` is high, `ad_oe` is 0 and the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-clock pulse per oscillator period; counts the hold-off |
| pwr_ok | input | 1 | Supply valid (1) or below the power-fail threshold (0) |
| cs_n | input | 1 | Chip select, active low |
| as_i | input | 1 | Address strobe; its falling edge captures the address |
| ds_i | input | 1 | Data strobe, active high |
| rd_wrn | input | 1 | 1 = read cycle, 0 = write cycle |
| ad_in | input | DATA_W | Shared address/data lines, input side |
| ad_out | output | DATA_W | Shared lines, output side (read data) |
| ad_oe | output | 1 | Output enable for `ad_out`; 0 means high impedance |

## Verification
The bench builds the block with 8-bit data, a 7-bit address, two synchroniser stages and a hold-off of only 16 ticks, pulsing the oscillator tick every fourth clock. The short hold-off keeps the whole recovery window to a few dozen clocks. That lets one run cover a blocked write just after power returns, a read-back once the window has closed, and a full write/read sweep of all 128 locations with two data patterns. The default 6,554-tick count is exercised only through the same counter logic at its larger width.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  // Bus cycle phase seen in the system clock domain.
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_DATA = 1'b1
  } phase_t;

  // Bit positions inside the synchronised control vector.
  localparam int CTL_RWN = 0;
  localparam int CTL_DS  = 1;
  localparam int CTL_AS  = 2;
  localparam int CTL_CSN = 3;
  localparam int CTL_PWR = 4;
  localparam int CTL_W   = 5;

  // Idle value of each control pin: power bad, deselected, strobes low, read.
  localparam logic [CTL_W-1:0] CTL_IDLE = 5'b0_1_0_0_1;

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= RST_VAL;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/mbus_lockout.sv
module mbus_lockout #(
  parameter int HOLDOFF_TICKS = 6554
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_s,
  input  logic osc_tick,
  output logic locked
);

  localparam int               CNT_W  = $clog2(HOLDOFF_TICKS + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLDOFF_TICKS);

  logic [CNT_W-1:0] cnt_q;

  // Reload while power is bad, count down on ticks once it is good.
  always_ff @(posedge clk) begin
    if (rst || !pwr_s)                 cnt_q <= HOLD_V;
    else if (osc_tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) locked <= 1'b1;
    else     locked <= !pwr_s || (cnt_q != '0);
  end

  // R7: a power return always starts from a full hold-off with access locked.
  a_r7_full_reload: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_s) |-> (cnt_q == HOLD_V) && locked);

  // R7: the lock only releases when power was good.
  a_r7_release_powered: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(pwr_s));

endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mbus_regif.sv
module mbus_regif
  import mbus_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 7,
  parameter int SYNC_STAGES   = 2,
  parameter int HOLDOFF_TICKS = 6554
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              pwr_ok,
  input  logic              cs_n,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              rd_wrn,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe
);

  // Synchronised control pins
  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic             pwr_s, csn_s, as_s, ds_s, rwn_s;
  logic [DATA_W-1:0] ad_s;

  always_comb begin
    ctl_raw          = '0;
    ctl_raw[CTL_RWN] = rd_wrn;
    ctl_raw[CTL_DS]  = ds_i;
    ctl_raw[CTL_AS]  = as_i;
    ctl_raw[CTL_CSN] = cs_n;
    ctl_raw[CTL_PWR] = pwr_ok;
  end

  mbus_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  // Data lines delayed by the same depth so they stay aligned with the strobes.
  mbus_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ad_sync (
    .clk(clk), .rst(rst), .d(ad_in), .q(ad_s)
  );

  assign rwn_s = ctl_s[CTL_RWN];
  assign ds_s  = ctl_s[CTL_DS];
  assign as_s  = ctl_s[CTL_AS];
  assign csn_s = ctl_s[CTL_CSN];
  assign pwr_s = ctl_s[CTL_PWR];

  // Edge detection
  logic as_p, ds_p, as_fall, ds_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      as_p <= 1'b0;
      ds_p <= 1'b0;
    end else begin
      as_p <= as_s;
      ds_p <= ds_s;
    end
  end

  assign as_fall = as_p && !as_s;
  assign ds_fall = ds_p && !ds_s;

  // Power lockout
  logic locked;

  mbus_lockout #(.HOLDOFF_TICKS(HOLDOFF_TICKS)) u_lockout (
    .clk(clk), .rst(rst), .pwr_s(pwr_s), .osc_tick(osc_tick), .locked(locked)
  );

  // Cycle phase and address capture
  phase_t            phase;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      addr_q <= '0;
    end else if (as_fall) begin
      phase  <= PH_DATA;
      addr_q <= ad_s[ADDR_W-1:0];
    end else if (ds_fall) begin
      phase  <= PH_IDLE;
    end
  end

  // Access control and storage
  logic              sel, mem_we;
  logic [DATA_W-1:0] rd_data;

  assign sel    = !csn_s && !locked;
  assign mem_we = ds_fall && !rwn_s && sel && (phase == PH_DATA);

  mbus_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(mem_we), .waddr(addr_q), .wdata(ad_s),
    .raddr(addr_q), .rdata(rd_data)
  );

  // Registered bus outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ad_oe  <= 1'b0;
      ad_out <= '0;
    end else begin
      ad_oe  <= ds_s && rwn_s && sel && (phase == PH_DATA);
      ad_out <= rd_data;
    end
  end

  // R1: the captured location holds through the data phase.
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && !as_fall) |=> $stable(addr_q));

  // R4/R5: the lines are only turned on by a read strobe.
  a_r4_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    $rose(ad_oe) |-> $past(rwn_s && ds_s));

  // R6: bad power never lets a drive through two cycles on.
  a_r6_no_drive_unpowered: assert property (@(posedge clk) disable iff (rst)
    !pwr_s |-> ##2 !ad_oe);

  // R6: a store only happens when power was already good.
  a_r6_no_write_unpowered: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(pwr_s));

  // R8: deselection turns the lines off on the next clock.
  a_r8_no_drive_deselected: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !ad_oe);

endmodule

// File: tb/test_mbus_regif.sv
module test_mbus_regif;

  localparam int DW    = 8;
  localparam int AW    = 7;
  localparam int HOLD  = 16;
  localparam int DEPTH = 2 ** AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          osc_tick = 1'b0;
  logic          pwr_ok = 1'b1;
  logic          cs_n = 1'b0;
  logic          as_i = 1'b0;
  logic          ds_i = 1'b0;
  logic          rd_wrn = 1'b1;
  logic [DW-1:0] ad_in = '0;
  logic [DW-1:0] ad_out;
  logic          ad_oe;

  always #10 clk = ~clk;

  mbus_regif #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2), .HOLDOFF_TICKS(HOLD)) i_mbus_regif (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .pwr_ok(pwr_ok), .cs_n(cs_n),
    .as_i(as_i), .ds_i(ds_i), .rd_wrn(rd_wrn), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );

  typedef struct {
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t          sbq[$];
  logic [DW-1:0] model [DEPTH];
  int            n_vec = 0;
  int            n_bad = 0;
  bit            rd_window = 1'b0;
  bit            oe_prev = 1'b0;
  bit            done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Oscillator tick every fourth clock
  initial begin
    forever begin
      wait_n(3);
      osc_tick = 1'b1;
      wait_n(1);
      osc_tick = 1'b0;
    end
  end

  task automatic addr_phase(input logic [DW-1:0] a);
    @(negedge clk);
    ad_in = a;
    as_i  = 1'b1;
    wait_n(3);
    as_i  = 1'b0;
    wait_n(4);
  endtask

  task automatic bus_write(input logic [DW-1:0] a, input logic [DW-1:0] d, input bit takes);
    addr_phase(a);
    ad_in  = d;
    rd_wrn = 1'b0;
    wait_n(1);
    ds_i   = 1'b1;
    wait_n(4);
    ds_i   = 1'b0;
    wait_n(4);
    rd_wrn = 1'b1;
    wait_n(2);
    if (takes) model[a[AW-1:0]] = d;
  endtask

  // A driving read pushes the expected byte; a blocked read checks for silence.
  task automatic bus_read(input logic [DW-1:0] a, input bit drive, input string tag);
    bit   saw = 1'b0;
    exp_t e;
    addr_phase(a);
    if (drive) begin
      e.data = model[a[AW-1:0]];
      e.tag  = tag;
      sbq.push_back(e);
    end
    rd_window = 1'b1;
    ds_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ad_oe) saw = 1'b1;
    end
    ds_i = 1'b0;
    wait_n(4);
    chk(ad_oe == 1'b0, "R5 drive released after strobe", {7'd0, ad_oe}, 8'h00);
    rd_window = 1'b0;
    if (!drive) chk(!saw, tag, {7'd0, saw}, 8'h00);
    wait_n(2);
  endtask

  // Monitor: pops the scoreboard on every rise of the output enable.
  always @(negedge clk) begin
    if (!rst) begin
      if (ad_oe && !oe_prev) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R5 R6 R8 unexpected drive", ad_out, 8'h00);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(ad_out === e.data, e.tag, ad_out, e.data);
        end
      end
      if (ad_oe && !rd_window) chk(1'b0, "R5 drive outside read phase", 8'h01, 8'h00);
      oe_prev <= ad_oe;
    end
  end

  initial begin
    wait_n(5);
    chk(ad_oe == 1'b0, "R9 reset output enable", {7'd0, ad_oe}, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    // R7: hold-off after reset blocks reads.
    bus_read(8'h00, 1'b0, "R7 read blocked after reset");
    wait_n(100);

    // R1 R3 R4: fill and read back every location.
    for (int a = 0; a < DEPTH; a++) bus_write(8'(a), 8'(a) ^ 8'h5A, 1'b1);
    for (int a = 0; a < DEPTH; a++) bus_read(8'(a), 1'b1, "R1 R3 R4 readback pattern A");

    // R2: bit 7 of the address is ignored.
    bus_write(8'h83, 8'hC3, 1'b1);
    bus_read(8'h03, 1'b1, "R2 alias low address");
    bus_read(8'h83, 1'b1, "R2 alias high address");

    // R6: power fail blocks writes and drive.
    pwr_ok = 1'b0;
    wait_n(6);
    bus_write(8'h0A, 8'h00, 1'b0);
    bus_read(8'h0A, 1'b0, "R6 read blocked unpowered");

    // R7: inside the hold-off after power returns.
    pwr_ok = 1'b1;
    bus_write(8'h0B, 8'h00, 1'b0);
    bus_read(8'h0B, 1'b0, "R7 read blocked in hold-off");
    wait_n(120);
    bus_read(8'h0A, 1'b1, "R6 write during power fail ignored");
    bus_read(8'h0B, 1'b1, "R7 write during hold-off ignored");

    // R8: chip select gates access.
    cs_n = 1'b1;
    wait_n(4);
    bus_write(8'h14, 8'hFF, 1'b0);
    bus_read(8'h14, 1'b0, "R8 read blocked deselected");
    cs_n = 1'b0;
    wait_n(4);
    bus_read(8'h14, 1'b1, "R8 write while deselected ignored");

    // R3 R4: second pattern over every location.
    for (int a = 0; a < DEPTH; a++) bus_write(8'(a), ~8'(a), 1'b1);
    for (int a = 0; a < DEPTH; a++) bus_read(8'(a), 1'b1, "R3 R4 readback pattern B");

    wait_n(4);
    chk(sbq.size() == 0, "R4 all expected reads seen", 8'(sbq.size()), 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule